// File: doc/BRIEF.md
# Synchronous Offset-Paced Byte Transfer Engine

This block moves a counted run of bytes across a parallel bus using a synchronous, offset-paced handshake. In the sending direction it takes bytes from a FIFO and puts out one strobe per byte at a programmed pacing. It does not wait for each reply before sending the next strobe. It keeps a count of strobes that have not yet been answered, and it stops sending when that count reaches a programmed window (1 to 15). Each reply strobe from the far side frees one slot in the window.

In the receiving direction it captures one byte on every incoming strobe and pushes the byte into the local FIFO. For each byte received it sends back one answering strobe, using the same pacing.

Before starting, the user sets the direction, the window size, a minimum strobe-to-strobe period, separate high and low strobe widths, a fast-timing select and a byte count. The user then pulses `start`. The block holds `busy` until every byte has moved and every outstanding strobe has been answered, and then pulses `done`. A window value of zero is reserved for the non-synchronous mode, which this block does not handle, so a start with a zero window is refused.

Top module: `sync_xfer_engine`

## Requirements
- R1: After reset, `strb_out`, `busy`, `done`, `tx_pop` and `rx_push` are all 0.
- R2: A `start` pulse is accepted only when `busy` is 0, `xfer_count` is nonzero and `cfg_offset` is nonzero. Any other `start` has no effect: no strobe is sent, and a transfer already running keeps its original byte count.
- R3: In send mode (`cfg_send`=1), each strobe carries the next FIFO byte in FIFO order, with one `tx_pop` per byte. `data_out` already holds that byte on the clock before `strb_out` rises, and stays unchanged until `strb_out` falls.
- R4: `strb_out` stays high for exactly max(`cfg_assert_w`, F) cycles and stays low for at least max(`cfg_negate_w`, F) cycles between strobes. F is 18 cycles when `cfg_fast`=0 and 6 cycles when `cfg_fast`=1.
- R5: Two consecutive rising edges of `strb_out` are at least `cfg_period` cycles apart.
- R6: In send mode, the number of sent but unanswered strobes never exceeds `cfg_offset`. When it equals `cfg_offset`, no new strobe is sent until a reply strobe (a rising edge on `strb_in`) arrives.
- R7: In send mode, no strobe is sent while `tx_valid` is 0.
- R8: In receive mode (`cfg_send`=0), each rising edge of `strb_in` pushes the `data_in` value present at the synchronised edge out on `rx_data`, with `rx_push` high for one cycle. Edges that arrive after `xfer_count` bytes have been taken push nothing.
- R9: In receive mode, the block sends exactly one answering strobe per byte taken, with the timing of R4 and R5.
- R10: In send mode exactly `xfer_count` strobes are sent. `busy` falls, and `done` pulses high for one cycle, only after the count is used up and no strobe is left unanswered (send mode) or owed (receive mode).
- R11: In send mode, a reply strobe that arrives while no strobe is outstanding is ignored and does not grant an extra slot in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_send | input | 1 | 1 = send bytes, 0 = receive bytes; taken at start |
| cfg_fast | input | 1 | Selects the 6-cycle width floor instead of 18; taken at start |
| cfg_offset | input | 4 | Window of unanswered strobes, 1..15; 0 refuses start |
| cfg_period | input | 8 | Minimum cycles from one strobe rise to the next |
| cfg_assert_w | input | 6 | Requested strobe high width in cycles |
| cfg_negate_w | input | 6 | Requested strobe low width in cycles |
| xfer_count | input | 24 | Number of bytes to move |
| start | input | 1 | One-cycle request to begin a transfer |
| tx_valid | input | 1 | Outgoing FIFO holds a byte |
| tx_data | input | 8 | Head byte of the outgoing FIFO |
| tx_pop | output | 1 | Takes the head byte of the outgoing FIFO |
| rx_push | output | 1 | Writes `rx_data` into the incoming FIFO |
| rx_data | output | 8 | Byte captured from the bus |
| strb_out | output | 1 | Outgoing bus strobe, active high |
| data_out | output | 8 | Outgoing bus data |
| strb_in | input | 1 | Incoming bus strobe, asynchronous, active high |
| data_in | input | 8 | Incoming bus data |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The send path is tried in four ways:
- with a far side that replies promptly, in both normal and fast timing. Requested widths below and above the floor show whether the clamp is applied to the right width.
- with no replies at all. This separates a correct stall at the window from running one strobe too far or stalling one strobe early.
- with an empty FIFO, and with a stray reply before any strobe has been sent. This shows whether the window counts only true replies.
- with a second start during a running transfer, which must not change the byte count.

The receive path is driven with one strobe more than the byte count. This checks both the byte order on the FIFO side and that the extra strobe is refused rather than pushed or answered.

// File: rtl/sxe_pkg.sv
package sxe_pkg;
  parameter int DAT_W     = 8;
  parameter int CNT_W     = 24;
  parameter int OFS_W     = 4;
  parameter int PER_W     = 8;
  parameter int WID_W     = 6;
  parameter int FLOOR_NRM = 18;
  parameter int FLOOR_FST = 6;

  typedef struct packed {
    logic             send;
    logic             fast;
    logic [OFS_W-1:0] ofs;
    logic [PER_W-1:0] period;
    logic [WID_W-1:0] a_w;
    logic [WID_W-1:0] n_w;
  } cfg_t;

  function automatic logic [WID_W-1:0] clamp_w(input logic [WID_W-1:0] w, input logic fast);
    logic [WID_W-1:0] fl;
    fl = fast ? WID_W'(FLOOR_FST) : WID_W'(FLOOR_NRM);
    return (w < fl) ? fl : w;
  endfunction
endpackage

// File: rtl/sxe_rst_sync.sv
module sxe_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end
  assign rst_n_o = s2_q;
endmodule

// File: rtl/sxe_in_sync.sv
module sxe_in_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);
  logic [2:0] sh_q, sh_d;
  always_comb sh_d = {sh_q[1:0], d_i};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
  assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/sxe_ofs_ctr.sv
module sxe_ofs_ctr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  logic [W-1:0] cnt_q, cnt_d;
  logic         en;

  always_comb begin
    en    = inc_i ^ dec_i;
    cnt_d = inc_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end
  assign cnt_o = cnt_q;

  // R6: the window counter never wraps upward
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_i) |-> (cnt_q != MAXV));
  // R11: a decrement is never requested with nothing outstanding
  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i) |-> (cnt_q != '0));
endmodule

// File: rtl/sxe_pulse_gen.sv
module sxe_pulse_gen
  import sxe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg_i,
  input  logic fire_i,
  output logic idle_o,
  output logic strb_o
);
  typedef enum logic [2:0] {PG_IDLE, PG_SETUP, PG_HIGH, PG_LOW, PG_GAP} pg_st_t;

  pg_st_t           st_q, st_d;
  logic [WID_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] el_q, el_d;
  logic [WID_W-1:0] eff_a, eff_n;
  logic             per_met;

  always_comb begin
    eff_a   = clamp_w(cfg_i.a_w, cfg_i.fast);
    eff_n   = clamp_w(cfg_i.n_w, cfg_i.fast);
    per_met = ({1'b0, el_q} + 1'b1) >= {1'b0, cfg_i.period};
    st_d    = st_q;
    cnt_d   = cnt_q;
    el_d    = (el_q == '1) ? el_q : el_q + 1'b1;
    case (st_q)
      PG_IDLE: begin
        el_d = '0;
        if (fire_i) st_d = PG_SETUP;
      end
      PG_SETUP: begin
        st_d  = PG_HIGH;
        cnt_d = eff_a - 1'b1;
      end
      PG_HIGH: begin
        if (cnt_q == '0) begin
          st_d  = PG_LOW;
          cnt_d = eff_n - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PG_LOW: begin
        if (cnt_q == '0) st_d = per_met ? PG_IDLE : PG_GAP;
        else             cnt_d = cnt_q - 1'b1;
      end
      PG_GAP: begin
        if (per_met) st_d = PG_IDLE;
      end
      default: st_d = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PG_IDLE;
      cnt_q <= '0;
      el_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      el_q  <= el_d;
    end
  end

  assign idle_o = (st_q == PG_IDLE);
  assign strb_o = (st_q == PG_HIGH);

  // R5: a new strobe is only requested once the previous one and its gap are over
  assert_fire_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |-> (st_q == PG_IDLE));
  // R3: the strobe rises only after a setup cycle
  assert_setup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_o) |-> $past(st_q) == PG_SETUP);
endmodule

// File: rtl/sync_xfer_engine.sv
module sync_xfer_engine
  import sxe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_send,
  input  logic             cfg_fast,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [WID_W-1:0] cfg_assert_w,
  input  logic [WID_W-1:0] cfg_negate_w,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic             start,
  input  logic             tx_valid,
  input  logic [DAT_W-1:0] tx_data,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [DAT_W-1:0] rx_data,
  output logic             strb_out,
  output logic [DAT_W-1:0] data_out,
  input  logic             strb_in,
  input  logic [DAT_W-1:0] data_in,
  output logic             busy,
  output logic             done
);
  localparam int OC_W = OFS_W + 1;

  logic            rst_s_n;
  logic            in_rise;
  logic            pg_idle;
  logic [OC_W-1:0] outs;

  cfg_t             cfg_q, cfg_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [DAT_W-1:0] dout_q, dout_d;
  logic [DAT_W-1:0] rxd_q, rxd_d;
  logic             push_q, push_d;

  logic accept, fire_tx, fire_rx, rx_take, fire, ctr_inc, ctr_dec, finish;

  sxe_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_s_n));
  sxe_in_sync  u_in  (.clk(clk), .rst_n(rst_s_n), .d_i(strb_in), .rise_o(in_rise));

  always_comb begin
    accept  = start && !busy_q && (xfer_count != '0) && (cfg_offset != '0);
    fire_tx = busy_q && cfg_q.send && (rem_q != '0) && (outs < {1'b0, cfg_q.ofs})
              && tx_valid && pg_idle;
    rx_take = busy_q && !cfg_q.send && (rem_q != '0) && in_rise;
    fire_rx = busy_q && !cfg_q.send && (outs != '0) && pg_idle;
    fire    = fire_tx || fire_rx;
    ctr_inc = fire_tx || rx_take;
    ctr_dec = cfg_q.send ? (busy_q && in_rise && (outs != '0)) : fire_rx;
    finish  = busy_q && (rem_q == '0) && (outs == '0) && pg_idle;
  end

  sxe_ofs_ctr #(.W(OC_W)) u_ofs (
    .clk(clk), .rst_n(rst_s_n), .inc_i(ctr_inc), .dec_i(ctr_dec), .cnt_o(outs)
  );

  sxe_pulse_gen u_pg (
    .clk(clk), .rst_n(rst_s_n), .cfg_i(cfg_q), .fire_i(fire),
    .idle_o(pg_idle), .strb_o(strb_out)
  );

  always_comb begin
    cfg_d  = cfg_q;
    busy_d = busy_q;
    done_d = 1'b0;
    rem_d  = rem_q;
    dout_d = dout_q;
    rxd_d  = rxd_q;
    push_d = 1'b0;
    if (accept) begin
      cfg_d.send   = cfg_send;
      cfg_d.fast   = cfg_fast;
      cfg_d.ofs    = cfg_offset;
      cfg_d.period = cfg_period;
      cfg_d.a_w    = cfg_assert_w;
      cfg_d.n_w    = cfg_negate_w;
      busy_d       = 1'b1;
      rem_d        = xfer_count;
    end else if (finish) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
    if (fire_tx) begin
      rem_d  = rem_q - 1'b1;
      dout_d = tx_data;
    end
    if (rx_take) begin
      rem_d  = rem_q - 1'b1;
      rxd_d  = data_in;
      push_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
      dout_q <= '0;
      rxd_q  <= '0;
      push_q <= 1'b0;
    end else begin
      if (accept)              cfg_q  <= cfg_d;
      busy_q <= busy_d;
      done_q <= done_d;
      if (accept || fire_tx || rx_take) rem_q <= rem_d;
      if (fire_tx)             dout_q <= dout_d;
      if (rx_take)             rxd_q  <= rxd_d;
      push_q <= push_d;
    end
  end

  assign tx_pop   = fire_tx;
  assign busy     = busy_q;
  assign done     = done_q;
  assign data_out = dout_q;
  assign rx_data  = rxd_q;
  assign rx_push  = push_q;

  // R6: unanswered strobes stay inside the programmed window
  assert_window_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy_q && cfg_q.send) |-> (outs <= {1'b0, cfg_q.ofs}));
  // R7: a byte is only taken from a FIFO that offers one
  assert_pop_valid_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    tx_pop |-> tx_valid);
  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done);
  // R10: busy only drops with nothing left to move or answer
  assert_clean_end_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(busy) |-> (rem_q == '0) && (outs == '0));
  // R2: no start is taken while a transfer runs
  assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy_q && !finish) |=> busy_q && $stable(cfg_q));
endmodule

// File: tb/sync_xfer_engine_bench.sv
module sync_xfer_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_send = 1'b1, cfg_fast = 1'b0;
  logic [3:0] cfg_offset = 4'd0;
  logic [7:0] cfg_period = 8'd0;
  logic [5:0] cfg_assert_w = 6'd0, cfg_negate_w = 6'd0;
  logic [23:0] xfer_count = 24'd0;
  logic       start = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_pop, rx_push, strb_out, busy, done;
  logic [7:0] rx_data, data_out;
  logic       rep_strb = 1'b0, drv_strb = 1'b0;
  logic [7:0] data_in = 8'd0;
  wire        strb_in = rep_strb | drv_strb;

  sync_xfer_engine u_sync_xfer_engine (
    .clk(clk), .rst_n(rst_n), .cfg_send(cfg_send), .cfg_fast(cfg_fast),
    .cfg_offset(cfg_offset), .cfg_period(cfg_period), .cfg_assert_w(cfg_assert_w),
    .cfg_negate_w(cfg_negate_w), .xfer_count(xfer_count), .start(start),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_data(rx_data), .strb_out(strb_out), .data_out(data_out), .strb_in(strb_in),
    .data_in(data_in), .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [7:0] src_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] rxe_q[$];
  logic tx_en = 1'b0;
  logic reply_en = 1'b0;
  logic mon_send = 1'b1;
  int exp_hi = 0, exp_lo = 0, exp_per = 0;
  int n_strb = 0, n_done = 0, n_push = 0, pend = 0;
  int hi_cnt = 0, lo_cnt = 0, last_rise = 0;
  logic have_rise = 1'b0, have_fall = 1'b0, prev_strb = 1'b0;
  logic [7:0] prev_data = 8'd0, rise_data = 8'd0;
  int rph = 0, rt = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int clampw(input int w, input logic f);
    int fl = f ? 6 : 18;
    return (w < fl) ? fl : w;
  endfunction

  // outgoing FIFO model
  always @(posedge clk) if (tx_pop && src_q.size() > 0) void'(src_q.pop_front());
  always @(negedge clk) begin
    tx_valid <= tx_en && (src_q.size() > 0);
    tx_data  <= (src_q.size() > 0) ? src_q[0] : 8'h00;
  end

  // monitor, scoreboard and reply model
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n) begin
      if (strb_out && !prev_strb) begin
        n_strb++;
        if (have_rise) chk(cyc - last_rise >= exp_per, "R5 spacing", cyc - last_rise, exp_per);
        if (have_fall) chk(lo_cnt >= exp_lo, "R4 low width", lo_cnt, exp_lo);
        if (mon_send) begin
          logic [7:0] e;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
          chk(data_out === e, "R3 byte order", data_out, e);
          chk(data_out === prev_data, "R3 setup", data_out, prev_data);
        end
        if (reply_en) pend++;
        rise_data = data_out; hi_cnt = 1; have_rise = 1'b1; last_rise = cyc;
      end else if (strb_out) begin
        hi_cnt++;
      end
      if (!strb_out && prev_strb) begin
        chk(hi_cnt == exp_hi, "R4 high width", hi_cnt, exp_hi);
        if (mon_send) chk(data_out === rise_data, "R3 hold", data_out, rise_data);
        lo_cnt = 1; have_fall = 1'b1;
      end else if (!strb_out) begin
        lo_cnt++;
      end
      prev_strb = strb_out; prev_data = data_out;
      if (rx_push) begin
        logic [7:0] e;
        n_push++;
        e = (rxe_q.size() > 0) ? rxe_q.pop_front() : 8'hxx;
        chk(rx_data === e, "R8 received byte", rx_data, e);
      end
      if (done) n_done++;
      case (rph)
        0: if (pend > 0) begin pend--; rep_strb <= 1'b1; rph = 1; rt = 4; end
        1: begin rt--; if (rt == 0) begin rep_strb <= 1'b0; rph = 2; rt = 4; end end
        default: begin rt--; if (rt == 0) rph = 0; end
      endcase
    end
  end

  task automatic clear_mon();
    n_strb = 0; n_done = 0; n_push = 0;
    have_rise = 1'b0; have_fall = 1'b0;
  endtask

  task automatic do_start(input logic snd, input logic fst, input int ofs, input int per,
                          input int aw, input int nw, input int cnt);
    @(negedge clk);
    cfg_send = snd; cfg_fast = fst; cfg_offset = 4'(ofs); cfg_period = 8'(per);
    cfg_assert_w = 6'(aw); cfg_negate_w = 6'(nw); xfer_count = 24'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int maxc);
    for (int i = 0; i < maxc && n_done == 0; i++) @(negedge clk);
  endtask

  task automatic load(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      src_q.push_back(base + 8'(i));
      exp_q.push_back(base + 8'(i));
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic expect_push);
    @(negedge clk);
    data_in = b;
    if (expect_push) rxe_q.push_back(b);
    repeat (2) @(negedge clk);
    drv_strb = 1'b1;
    repeat (6) @(negedge clk);
    drv_strb = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(strb_out == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 reset outputs", busy, 0);
    chk(tx_pop == 1'b0 && rx_push == 1'b0, "R1 reset fifo strobes", tx_pop, 0);

    // R2 refused starts: zero window, zero count
    clear_mon(); load(2, 8'h50); tx_en = 1'b1;
    do_start(1'b1, 1'b1, 0, 10, 6, 6, 2);
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && n_strb == 0, "R2 zero window refused", n_strb, 0);
    do_start(1'b1, 1'b1, 3, 10, 6, 6, 0);
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && n_strb == 0, "R2 zero count refused", n_strb, 0);
    src_q.delete(); exp_q.delete();

    // normal timing, prompt replies, clamp of high width, restart while busy
    clear_mon(); mon_send = 1'b1; reply_en = 1'b1;
    exp_hi = clampw(4, 1'b0); exp_lo = clampw(20, 1'b0); exp_per = 50;
    load(6, 8'h11);
    do_start(1'b1, 1'b0, 4, 50, 4, 20, 6);
    repeat (60) @(negedge clk);
    do_start(1'b1, 1'b0, 4, 50, 4, 20, 2);   // R2: ignored while busy
    wait_done(5000);
    repeat (20) @(negedge clk);
    chk(n_strb == 6, "R10 strobe total normal (R2 restart ignored)", n_strb, 6);
    chk(n_done == 1 && busy == 1'b0, "R10 done once", n_done, 1);
    chk(exp_q.size() == 0, "R3 all bytes sent", exp_q.size(), 0);

    // fast timing, widths above the floor
    clear_mon(); exp_hi = 9; exp_lo = 7; exp_per = 10;
    load(5, 8'hA0);
    do_start(1'b1, 1'b1, 2, 10, 9, 7, 5);
    wait_done(5000);
    repeat (20) @(negedge clk);
    chk(n_strb == 5 && n_done == 1, "R10 fast transfer total", n_strb, 5);

    // R6 stall at the window with no replies
    clear_mon(); reply_en = 1'b0; exp_hi = 6; exp_lo = 6; exp_per = 12;
    load(5, 8'h30);
    do_start(1'b1, 1'b1, 3, 12, 3, 2, 5);
    repeat (400) @(negedge clk);
    chk(n_strb == 3, "R6 stalls exactly at window", n_strb, 3);
    chk(busy == 1'b1 && n_done == 0, "R10 no done while outstanding", n_done, 0);
    pend++;                                   // one reply frees one slot
    repeat (100) @(negedge clk);
    chk(n_strb == 4, "R6 one reply one strobe", n_strb, 4);
    pend = pend + 4;
    wait_done(3000);
    repeat (20) @(negedge clk);
    chk(n_strb == 5 && n_done == 1, "R10 stalled transfer completes", n_strb, 5);

    // R7 empty FIFO and R11 stray reply, window of one
    clear_mon(); tx_en = 1'b0;
    load(2, 8'hC0);
    do_start(1'b1, 1'b1, 1, 12, 6, 6, 2);
    repeat (10) @(negedge clk);
    pend++;                                   // stray reply, nothing outstanding
    repeat (60) @(negedge clk);
    chk(n_strb == 0, "R7 no strobe while FIFO empty", n_strb, 0);
    tx_en = 1'b1;
    repeat (150) @(negedge clk);
    chk(n_strb == 1, "R11 stray reply gave no extra slot", n_strb, 1);
    pend++;
    repeat (100) @(negedge clk);
    chk(n_strb == 2, "R6 second strobe after real reply", n_strb, 2);
    pend++;
    wait_done(1000);
    repeat (10) @(negedge clk);
    chk(n_done == 1 && busy == 1'b0, "R10 window-one transfer done", n_done, 1);

    // receive: four bytes expected, a fifth strobe must be refused
    clear_mon(); mon_send = 1'b0; exp_hi = 6; exp_lo = 6; exp_per = 8;
    do_start(1'b0, 1'b1, 4, 8, 2, 2, 4);
    send_byte(8'h91, 1'b1);
    send_byte(8'h3C, 1'b1);
    send_byte(8'hE7, 1'b1);
    send_byte(8'h05, 1'b1);
    send_byte(8'h77, 1'b0);
    wait_done(2000);
    repeat (40) @(negedge clk);
    chk(n_push == 4, "R8 one push per byte, extra refused", n_push, 4);
    chk(rxe_q.size() == 0, "R8 all bytes received", rxe_q.size(), 0);
    chk(n_strb == 4, "R9 one answer per byte", n_strb, 4);
    chk(n_done == 1 && busy == 1'b0, "R10 receive done", n_done, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule